// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns host write cycles into the command protocol of a parallel NOR flash. Every write cycle carries a byte address and a data byte. The sequencer follows the unlock handshake, the command byte and the operand cycle. It keeps the byte array that reads return. Programming clears bits in that array. Sector erase and chip erase refill it with ones.

For each state the sequencer drives a two-bit read-mode code. A read multiplexer outside the block uses this code to choose between array data, identification data, status and the query table. When a program or an erase is accepted, the sequencer raises a one-cycle start pulse for the status and timing block. An erase holds the sequencer busy until that block returns an `erase_done` pulse.

An unlock bypass mode shortens programming to two cycles. A query-table shortcut, a reset byte and a write-protect input round out the protocol.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `rd_mode` is 0 (array), `prog_start` and `erase_start` are low, and every array byte reads 0xFF.
- R2: An unlock takes two writes: 0xAA at unlock offset 0, then 0x55 at unlock offset 1. The offset is the address within its sector, shifted right by log2 of the bus width in bytes. Defaults are 0x55 and 0x2A. Any other write in either slot returns the sequencer to read mode, and the following command byte then has no effect.
- R3: After an unlock, the command byte must be written at unlock offset 0. The only exception is bypass mode, where any offset is accepted. The accepted bytes are 0x20 (enter bypass), 0x80 (erase setup), 0x90 (identification) and 0xA0 (program arm). Any other byte, or the wrong offset, returns to read mode.
- R4: The write that follows a program arm ANDs its data into the addressed byte. `prog_start` is high for exactly the one cycle after that write. The sequencer then returns to read mode, or in bypass to the command slot.
- R5: Once bypass is entered, each program needs only 0xA0 followed by the data, both at any address. Writing 0x90 and then 0x00 leaves bypass, after which a bare 0xA0 is no longer accepted.
- R6: Erase setup (0x80) needs a second unlock pair, followed by one of two bytes. 0x10 at unlock offset 0 erases the whole chip. 0x30 at any address erases the sector containing that address. The affected bytes become 0xFF. `erase_start` pulses for one cycle, and `erase_chip` is high with it for a chip erase only. `rd_mode` is 2 until `erase_done`. 0x10 at any other offset aborts the erase without a pulse.
- R7: Writes other than 0xF0 during an active erase are ignored: the array is unchanged, no pulse appears and `rd_mode` stays 2.
- R8: A write of 0xF0 returns the sequencer to read mode (`rd_mode` 0) from any state except program-armed. In the program-armed state 0xF0 is programmed like any other data.
- R9: 0x98 written at offset 0x55 enters query mode (`rd_mode` 3). This works from read mode, from the first slot of the second erase unlock, and from identification mode. Any write in query mode returns to read mode.
- R10: `rd_mode` follows the state from the cycle after the write edge. It is 1 in identification mode, 2 while a program is armed or an erase runs, 3 in query mode, and 0 in every other state.
- R11: While `wr_protect` is high, program and erase leave the array unchanged. Their start pulses and state changes still occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data / command byte |
| wr_protect | input | 1 | Blocks array changes by program and erase |
| erase_done | input | 1 | Erase completion pulse from the timing block |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| rd_mode | output | 2 | Read source: 0 array, 1 ident, 2 status, 3 query |
| prog_start | output | 1 | One-cycle pulse after a program write |
| erase_start | output | 1 | One-cycle pulse after an erase command |
| erase_chip | output | 1 | High with `erase_start` for chip erase |

## Verification
The state register and the array update on the clock edge that samples a write. `rd_mode` and `rd_data` are therefore valid right after that edge, and the bench reads them one nanosecond later, before the next edge. The start pulses come from an extra register stage, so they are due during the cycle after the write edge. The driver queues one expected pulse record per write, and a monitor compares it at the following falling edge. The monitor also flags any pulse that appears in a cycle with nothing queued.

// File: rtl/nor_cmd_pkg.sv
// Package: shared codes and types for the NOR command sequencer.
// Assumes byte-wide command data regardless of the bus width.
package nor_cmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        S_READ, S_UNLK_B, S_CMD, S_PROG, S_ERA_A, S_ERA_B,
        S_ERA_CMD, S_ERASING, S_IDENT, S_QUERY
    } seq_state_e;

    typedef struct packed {
        logic is_u0;
        logic is_u1;
        logic is_qry;
    } addr_hit_t;

    localparam logic [7:0] CB_RESET  = 8'hF0;
    localparam logic [7:0] CB_KEY_A  = 8'hAA;
    localparam logic [7:0] CB_KEY_B  = 8'h55;
    localparam logic [7:0] CB_BYPASS = 8'h20;
    localparam logic [7:0] CB_ERASE  = 8'h80;
    localparam logic [7:0] CB_IDENT  = 8'h90;
    localparam logic [7:0] CB_PROG   = 8'hA0;
    localparam logic [7:0] CB_QUERY  = 8'h98;
    localparam logic [7:0] CB_CHIP   = 8'h10;
    localparam logic [7:0] CB_SECTOR = 8'h30;
    localparam logic [7:0] CB_BYP_EX = 8'h00;
    localparam int         QRY_OFF   = 'h55;

endpackage

// File: rtl/nor_addr_match.sv
// Module: turns the in-sector byte address into a word offset and flags the
// special offsets. Assumes BUS_BYTES is a power of two below SECTOR_BYTES.
module nor_addr_match
    import nor_cmd_pkg::*;
#(
    parameter int SECTOR_BYTES = 128,
    parameter int BUS_BYTES    = 1,
    parameter int UNLOCK0      = 'h55,
    parameter int UNLOCK1      = 'h2A,
    localparam int SEC_W = $clog2(SECTOR_BYTES),
    localparam int SHIFT = $clog2(BUS_BYTES),
    localparam int OFF_W = SEC_W - SHIFT
) (
    input  logic [SEC_W-1:0] sec_addr,
    output addr_hit_t        hit
);

    logic [OFF_W-1:0] word_off;

    // Purpose: scale the byte offset to the bus word and compare.
    always_comb begin
        word_off   = sec_addr[SEC_W-1:SHIFT];
        hit.is_u0  = (word_off == OFF_W'(UNLOCK0));
        hit.is_u1  = (word_off == OFF_W'(UNLOCK1));
        hit.is_qry = (word_off == OFF_W'(QRY_OFF));
    end

endmodule

// File: rtl/nor_seq_ctrl.sv
// Module: command state machine. It consumes one write per cycle, issues
// same-cycle array strobes and registered start pulses, and decodes the read
// mode from its state. Assumes erase_done arrives only after an erase start.
module nor_seq_ctrl
    import nor_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  addr_hit_t  hit,
    input  logic       erase_done,
    output logic       prog_now,
    output logic       sec_now,
    output logic       chip_now,
    output logic [1:0] rd_mode,
    output logic       prog_start,
    output logic       erase_start,
    output logic       erase_chip
);

    seq_state_e state, state_n;
    logic       bypass, byp_n, abort;

    // Purpose: next state, bypass flag and array strobes for this cycle.
    always_comb begin
        state_n  = state;
        byp_n    = bypass;
        prog_now = 1'b0;
        sec_now  = 1'b0;
        chip_now = 1'b0;
        abort    = 1'b0;
        if (wr_en && wr_data == CB_RESET && state != S_PROG) begin
            abort = 1'b1;
        end else if (state == S_ERASING) begin
            if (erase_done) state_n = bypass ? S_CMD : S_READ;
        end else if (wr_en) begin
            case (state)
                S_READ, S_ERA_A: begin
                    if (hit.is_qry && wr_data == CB_QUERY)
                        state_n = S_QUERY;
                    else if (hit.is_u0 && wr_data == CB_KEY_A)
                        state_n = (state == S_READ) ? S_UNLK_B : S_ERA_B;
                    else
                        abort = 1'b1;
                end
                S_UNLK_B, S_ERA_B: begin
                    if (hit.is_u1 && wr_data == CB_KEY_B)
                        state_n = (state == S_UNLK_B) ? S_CMD : S_ERA_CMD;
                    else
                        abort = 1'b1;
                end
                S_CMD: begin
                    if (!bypass && !hit.is_u0) abort = 1'b1;
                    else begin
                        case (wr_data)
                            CB_BYPASS: begin byp_n = 1'b1; state_n = S_CMD; end
                            CB_ERASE:  state_n = S_ERA_A;
                            CB_IDENT:  state_n = S_IDENT;
                            CB_PROG:   state_n = S_PROG;
                            default:   abort = 1'b1;
                        endcase
                    end
                end
                S_PROG: begin
                    prog_now = 1'b1;
                    state_n  = bypass ? S_CMD : S_READ;
                end
                S_ERA_CMD: begin
                    if (wr_data == CB_CHIP && hit.is_u0) begin
                        chip_now = 1'b1;
                        state_n  = S_ERASING;
                    end else if (wr_data == CB_SECTOR) begin
                        sec_now = 1'b1;
                        state_n = S_ERASING;
                    end else abort = 1'b1;
                end
                S_IDENT: begin
                    if (hit.is_qry && wr_data == CB_QUERY) state_n = S_QUERY;
                    else abort = 1'b1;
                end
                default: abort = 1'b1;
            endcase
        end
        if (abort) begin
            state_n = S_READ;
            byp_n   = 1'b0;
        end
    end

    // Purpose: hold state, bypass flag and the registered start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_READ;
            bypass      <= 1'b0;
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            erase_chip  <= 1'b0;
        end else begin
            state       <= state_n;
            bypass      <= byp_n;
            prog_start  <= prog_now;
            erase_start <= sec_now | chip_now;
            erase_chip  <= chip_now;
        end
    end

    // Purpose: map the state onto the read-source code.
    always_comb begin
        case (state)
            S_IDENT:           rd_mode = RD_IDENT;
            S_PROG, S_ERASING: rd_mode = RD_STATUS;
            S_QUERY:           rd_mode = RD_QUERY;
            default:           rd_mode = RD_ARRAY;
        endcase
    end

endmodule

// File: rtl/nor_byte_array.sv
// Module: byte storage with AND-programming and sector/chip fill to 0xFF.
// Assumes at most one strobe per cycle and NUM_SECTORS of at least two.
module nor_byte_array #(
    parameter int SECTOR_BYTES = 128,
    parameter int NUM_SECTORS  = 4,
    localparam int DEPTH  = SECTOR_BYTES * NUM_SECTORS,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SEC_W  = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              sec_en,
    input  logic              chip_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    // Purpose: apply erase fill or AND-program to each byte.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= 8'hFF;
            else if (chip_en || (sec_en &&
                     (ADDR_W - SEC_W)'(i / SECTOR_BYTES) == wr_addr[ADDR_W-1:SEC_W]))
                mem[i] <= 8'hFF;
            else if (prog_en && wr_addr == ADDR_W'(i))
                mem[i] <= mem[i] & wr_data;
        end
    end

    // Purpose: asynchronous array read port.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nor_cmd_seq.sv
// Module: top of the NOR command sequencer. It ties the offset matcher, the
// control FSM and the byte array together and applies write protection.
// Assumes one host write per wr_en cycle.
module nor_cmd_seq #(
    parameter int SECTOR_BYTES = 128,
    parameter int NUM_SECTORS  = 4,
    parameter int BUS_BYTES    = 1,
    parameter int UNLOCK0      = 'h55,
    parameter int UNLOCK1      = 'h2A,
    parameter int ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_protect,
    input  logic              erase_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [1:0]        rd_mode,
    output logic              prog_start,
    output logic              erase_start,
    output logic              erase_chip
);

    import nor_cmd_pkg::*;
    localparam int SEC_W = $clog2(SECTOR_BYTES);

    addr_hit_t hit;
    logic      prog_now, sec_now, chip_now;

    nor_addr_match #(
        .SECTOR_BYTES(SECTOR_BYTES), .BUS_BYTES(BUS_BYTES),
        .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
    ) i_match (
        .sec_addr(wr_addr[SEC_W-1:0]),
        .hit     (hit)
    );

    nor_seq_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .hit        (hit),
        .erase_done (erase_done),
        .prog_now   (prog_now),
        .sec_now    (sec_now),
        .chip_now   (chip_now),
        .rd_mode    (rd_mode),
        .prog_start (prog_start),
        .erase_start(erase_start),
        .erase_chip (erase_chip)
    );

    nor_byte_array #(
        .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS)
    ) i_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .prog_en(prog_now & ~wr_protect),
        .sec_en (sec_now & ~wr_protect),
        .chip_en(chip_now & ~wr_protect),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
// Module: protocol checker bound to the sequencer top; observes ports only.
module nor_cmd_seq_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              wr_protect,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [1:0]        rd_mode,
    input logic              prog_start,
    input logic              erase_start
);

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R4

    AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> rd_mode == 2'd2); // R6

    AST_ESCAPE_F0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'hF0 && rd_mode != 2'd2) |=> rd_mode == 2'd0); // R8

    AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_mode == 2'd3) |=> rd_mode == 2'd0); // R9

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_protect && $past(wr_protect) && $stable(rd_addr)) |-> $stable(rd_data)); // R11

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_protect(wr_protect), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_mode(rd_mode), .prog_start(prog_start), .erase_start(erase_start)
);

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/1ps
module test_nor_cmd_seq;

    localparam int AW = 9;
    localparam int DEPTH = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wr_protect = 1'b0;
    logic          erase_done = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [1:0]    rd_mode;
    logic          prog_start, erase_start, erase_chip;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] model [DEPTH];

    typedef struct {
        bit    prog;
        bit    era;
        bit    chip;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    nor_cmd_seq i_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_protect(wr_protect), .erase_done(erase_done),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_mode(rd_mode),
        .prog_start(prog_start), .erase_start(erase_start),
        .erase_chip(erase_chip)
    );

    task automatic chk(string req, int act, int exp_v);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // Driver: one write, then queue the pulse expected in the next cycle.
    task automatic wr(int a, int d, bit p = 0, bit e = 0, bit c = 0,
                      string req = "R2");
        exp_t it;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        it.prog = p; it.era = e; it.chip = c; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compare the start pulses one cycle after each write.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                chk({it.req, " prog_start"}, int'(prog_start), int'(it.prog));
                chk({it.req, " erase_start"}, int'(erase_start), int'(it.era));
                if (it.era) chk({it.req, " erase_chip"}, int'(erase_chip), int'(it.chip));
            end else if (prog_start || erase_start) begin
                fails++;
                $display("FAIL idle: actual pulses %b%b expected 00", prog_start, erase_start);
            end
        end
    end

    task automatic unlock();
        wr('h55, 'hAA);
        wr('h2A, 'h55);
    endtask

    task automatic look(int a, string req);
        rd_addr = AW'(a);
        #1;
        chk({req, " array byte"}, int'(rd_data), int'(model[a]));
    endtask

    task automatic mode_is(int m, string req);
        chk({req, " rd_mode"}, int'(rd_mode), m);
    endtask

    task automatic finish_erase();
        @(negedge clk); erase_done = 1'b1;
        @(posedge clk); #1; erase_done = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        mode_is(0, "R1");
        chk("R1 prog_start", int'(prog_start), 0);
        chk("R1 erase_start", int'(erase_start), 0);
        look(0, "R1"); look('h1FF, "R1");

        // R4 program and AND behaviour
        unlock(); wr('h55, 'hA0, 0, 0, 0, "R3");
        mode_is(2, "R10");
        wr('h10, 'h3C, 1, 0, 0, "R4"); model['h10] = 8'h3C;
        look('h10, "R4"); mode_is(0, "R4");
        unlock(); wr('h55, 'hA0); wr('h10, 'hF5, 1, 0, 0, "R4"); model['h10] &= 8'hF5;
        look('h10, "R4");

        // R2 bad unlock: command that follows is not taken
        wr('h55, 'hAA); wr('h2B, 'h55); wr('h55, 'hA0); wr('h11, 'h00, 0, 0, 0, "R2");
        look('h11, "R2"); mode_is(0, "R2");

        // R3 unknown byte and wrong offset
        unlock(); wr('h55, 'h77); wr('h11, 'h00, 0, 0, 0, "R3"); look('h11, "R3");
        unlock(); wr('h56, 'hA0); mode_is(0, "R3");
        wr('h11, 'h00, 0, 0, 0, "R3"); look('h11, "R3");

        // R9 / R10 identification then query
        unlock(); wr('h55, 'h90); mode_is(1, "R10");
        wr('h55, 'h98); mode_is(3, "R9");
        wr('h00, 'h12); mode_is(0, "R9");
        wr('h55, 'h98); mode_is(3, "R9");
        wr('h00, 'hF0); mode_is(0, "R8");
        unlock(); wr('h55, 'h80); wr('h55, 'h98); mode_is(3, "R9");
        wr('h00, 'h00); mode_is(0, "R9");

        // R8 F0 programmed when armed, reset in identification
        unlock(); wr('h55, 'hA0); wr('h20, 'hF0, 1, 0, 0, "R8"); model['h20] = 8'hF0;
        look('h20, "R8");
        unlock(); wr('h55, 'h90); wr('h33, 'hF0); mode_is(0, "R8");

        // R6 sector erase, R7 writes ignored while busy
        unlock(); wr('h55, 'hA0); wr('h90, 'h00, 1); model['h90] = 8'h00;
        unlock(); wr('h55, 'hA0); wr('h110, 'h00, 1); model['h110] = 8'h00;
        unlock(); wr('h55, 'h80); unlock();
        wr('h95, 'h30, 0, 1, 0, "R6");
        for (int i = 'h80; i < 'h100; i++) model[i] = 8'hFF;
        mode_is(2, "R6");
        look('h90, "R6"); look('h80, "R6"); look('h110, "R6"); look('h10, "R6");
        unlock(); wr('h55, 'hA0); wr('h111, 'h00, 0, 0, 0, "R7");
        look('h111, "R7"); mode_is(2, "R7");
        finish_erase(); mode_is(0, "R6");

        // R6 chip erase at wrong offset aborts
        unlock(); wr('h55, 'h80); unlock(); wr('h56, 'h10, 0, 0, 0, "R6");
        mode_is(0, "R6");

        // R11 write protect
        wr_protect = 1'b1;
        unlock(); wr('h55, 'hA0); wr('h30, 'h00, 1, 0, 0, "R11");
        look('h30, "R11");
        wr_protect = 1'b0;

        // R5 bypass programming and exit
        unlock(); wr('h55, 'h20); mode_is(0, "R5");
        wr('h123, 'hA0); wr('h40, 'h0F, 1, 0, 0, "R5"); model['h40] = 8'h0F;
        wr('h77, 'hA0); wr('h41, 'hF3, 1, 0, 0, "R5"); model['h41] = 8'hF3;
        look('h40, "R5"); look('h41, "R5");
        wr('h10, 'h90); mode_is(1, "R5");
        wr('h00, 'h00); mode_is(0, "R5");
        wr('h55, 'hA0); wr('h42, 'h00, 0, 0, 0, "R5"); look('h42, "R5");

        // R6 chip erase
        unlock(); wr('h55, 'h80); unlock(); wr('h55, 'h10, 0, 1, 1, "R6");
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        look('h10, "R6"); look('h110, "R6"); look('h40, "R6"); look('h20, "R6");
        finish_erase(); mode_is(0, "R6");

        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule